// File: doc/BRIEF.md
# One-Shot Pulse Generator

A synchronous, non-retriggerable monostable. It watches two trigger inputs of opposite sense: an active-low input `trig_a_n` and an active-high input `trig_b`. Each input enables the other. Together they form a "fire condition": `trig_a_n` low and `trig_b` high at the same time. When this condition appears while the block is idle, the block starts a pulse. The pulse lasts a programmed number of clock cycles. It is driven on a true output and on a complementary output.

Once a pulse runs, the block ignores its trigger inputs until the pulse has finished, so a pulse can be neither retriggered nor stretched. The active-low input `rst_n` overrides everything and ends a pulse at once. The block can also be armed while `rst_n` is held low, so that the rising edge of `rst_n` itself starts a pulse. All inputs are taken to be synchronous to `clk` already.

The controller has four states:
- ST_HOLD: reset is low and the block is not armed.
- ST_ARMED: reset is low and the fire condition has been entered.
- ST_IDLE: waiting for a trigger.
- ST_PULSE: a pulse is running.

It has these transitions:
- clear: any state other than ST_ARMED goes to ST_HOLD when `rst_n` is low. ST_HOLD stays in ST_HOLD unless it arms.
- arm: ST_HOLD goes to ST_ARMED on entry into the fire condition.
- release: ST_HOLD goes to ST_IDLE. ST_ARMED goes to ST_IDLE when the condition has gone.
- armed fire: ST_ARMED goes to ST_PULSE when the condition still holds.
- fire: ST_IDLE goes to ST_PULSE on entry into the condition.
- expire: ST_PULSE goes to ST_IDLE after the last counted cycle.

Top module: `oneshot_pulse`

## Requirements
- R1: At a clock edge where `rst_n` has been high for at least one full clock, `trig_a_n` falling (sampled 1 at the previous edge, 0 now) while `trig_b` is sampled 1 starts a pulse. A fall of `trig_a_n` while `trig_b` is 0 starts nothing.
- R2: Under the same reset rule, `trig_b` rising (0 at the previous edge, 1 now) while `trig_a_n` is sampled 0 starts a pulse. A rise of `trig_b` while `trig_a_n` is 1 starts nothing.
- R3: While a pulse runs, every change on `trig_a_n` and `trig_b` is ignored. The pulse neither restarts nor lengthens, and it is not followed by a second pulse.
- R4: While `rst_n` is low, `pulse_q` is 0 and `pulse_qn` is 1 in the same cycle, without waiting for a clock edge. A running pulse is dropped and does not resume after release unless R5 applies.
- R5: A rising edge of `rst_n` starts a pulse if two things hold: the fire condition holds at the release edge, and during the same low-reset period the condition was entered at a later edge than the first low edge. If the condition was already present throughout the reset period, release starts nothing.
- R6: The pulse length does not depend on how long the trigger condition lasts. The condition may drop right after triggering or may stay held throughout, and the pulse still runs its full length.
- R7: `width_cycles` is sampled at the edge that accepts the trigger. The pulse is then high for exactly that many cycles, and a value of 0 gives 1 cycle. Changes to `width_cycles` during a pulse have no effect on it.
- R8: A trigger edge that arrives on the clock edge ending the pulse's final cycle is ignored.
- R9: A fire-condition entry that coincides with the `rst_n` release edge, without prior arming, starts nothing. A trigger needs reset high at the previous edge.
- R10: `pulse_q` rises on the clock edge that samples the trigger and is registered. `pulse_qn` is always its complement, so it is 0 for the whole pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low overriding clear; its rising edge can fire an armed pulse |
| trig_a_n | input | 1 | Active-low trigger; a falling edge fires while `trig_b` is high |
| trig_b | input | 1 | Active-high trigger; a rising edge fires while `trig_a_n` is low |
| width_cycles | input | CNT_W | Pulse length in clock cycles, 0 treated as 1 |
| pulse_q | output | 1 | True pulse output |
| pulse_qn | output | 1 | Complementary pulse output |

## Verification
The properties assume three things about the inputs: they are synchronous, they change only between rising edges, and they stay stable around each edge. Under these assumptions "previous edge" has a single meaning for both triggers and for `rst_n`. The length properties also assume that `width_cycles` seen at the accepting edge is the value that governs the pulse. The stimulus honours all of this by changing every input just after a falling edge of `clk` and reading the outputs at falling edges. The one exception is the same-cycle reset check, which reads the outputs one nanosecond after dropping `rst_n`.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Controller states of the one-shot
    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_IDLE   = 2'd2,
        ST_PULSE  = 2'd3
    } os_state_e;

endpackage

// File: rtl/oneshot_trig.sv
// Fire-condition detector: condition level plus its entry edge.
module oneshot_trig (
    input  logic clk,
    input  logic trig_a_n,
    input  logic trig_b,
    output logic fire_cond,
    output logic cond_entry
);

    logic cond_q;

    assign fire_cond = ~trig_a_n & trig_b;

    // Pure data history; follows the inputs in every state, reset included.
    always_ff @(posedge clk) begin
        cond_q <= fire_cond;
    end

    assign cond_entry = fire_cond & ~cond_q;

endmodule

// File: rtl/oneshot_timer.sv
// Down-counter for the pulse length; loads width-1 (0 treated as 1).
module oneshot_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] width_in,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (load) begin
            remain <= (width_in == ZERO) ? ZERO : (width_in - ONE);
        end else if (run && (remain != ZERO)) begin
            remain <= remain - ONE;
        end
    end

    assign last = (remain == ZERO);

endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
    import oneshot_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_a_n,
    input  logic             trig_b,
    input  logic [CNT_W-1:0] width_cycles,
    output logic             pulse_q,
    output logic             pulse_qn
);

    os_state_e state, state_nx;
    logic      fire_cond;
    logic      cond_entry;
    logic      cnt_last;
    logic      start;
    logic      q_reg;

    oneshot_trig u_trig (
        .clk        (clk),
        .trig_a_n   (trig_a_n),
        .trig_b     (trig_b),
        .fire_cond  (fire_cond),
        .cond_entry (cond_entry)
    );

    oneshot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .load     (start),
        .run      (state == ST_PULSE),
        .width_in (width_cycles),
        .last     (cnt_last)
    );

    // Next-state logic
    always_comb begin
        state_nx = ST_HOLD;
        if (!rst_n) begin
            unique case (state)
                ST_HOLD:  state_nx = cond_entry ? ST_ARMED : ST_HOLD;  // arm
                ST_ARMED: state_nx = ST_ARMED;
                default:  state_nx = ST_HOLD;                          // clear
            endcase
        end else begin
            unique case (state)
                ST_HOLD:  state_nx = ST_IDLE;                                  // release
                ST_ARMED: state_nx = fire_cond ? ST_PULSE : ST_IDLE;           // armed fire / release
                ST_IDLE:  state_nx = cond_entry ? ST_PULSE : ST_IDLE;          // fire
                ST_PULSE: state_nx = cnt_last ? ST_IDLE : ST_PULSE;            // expire
                default:  state_nx = ST_HOLD;
            endcase
        end
    end

    assign start = (state_nx == ST_PULSE) && (state != ST_PULSE);

    // State register
    always_ff @(posedge clk) begin
        state <= state_nx;
    end

    // Output register; reset gates it without waiting for an edge
    always_ff @(posedge clk) begin
        q_reg <= (state_nx == ST_PULSE);
    end

    assign pulse_q  = q_reg & rst_n;
    assign pulse_qn = ~pulse_q;

endmodule

// File: rtl/oneshot_pulse_chk.sv
module oneshot_pulse_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_a_n,
    input logic             trig_b,
    input logic [CNT_W-1:0] width_cycles,
    input logic             pulse_q,
    input logic             pulse_qn
);

    localparam int LEN_W = CNT_W + 1;
    localparam logic [LEN_W-1:0] LEN_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

    logic             q_d;
    logic [CNT_W-1:0] w_d;
    logic [LEN_W-1:0] run_len;
    logic [LEN_W-1:0] exp_len;

    always_ff @(posedge clk) begin
        w_d <= width_cycles;
        if (!rst_n) begin
            q_d     <= 1'b0;
            run_len <= '0;
            exp_len <= LEN_ONE;
        end else begin
            q_d <= pulse_q;
            if (pulse_q && !q_d) begin
                run_len <= LEN_ONE;
                exp_len <= (w_d == '0) ? LEN_ONE : {1'b0, w_d};
            end else if (pulse_q) begin
                run_len <= run_len + LEN_ONE;
            end else begin
                run_len <= '0;
            end
        end
    end

    // R1 R2
    fire_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !pulse_q && !trig_a_n && trig_b
         && !(!$past(trig_a_n) && $past(trig_b)))
        |=> pulse_q);

    // R3
    no_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q && q_d) |-> (run_len < exp_len));

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_d && !pulse_q) |-> (run_len == exp_len));

    // R4
    release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && !(!trig_a_n && trig_b)) |=> !pulse_q);

    // R10
    qn_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_q) |-> $fell(pulse_qn));

endmodule

bind oneshot_pulse oneshot_pulse_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_a_n     (trig_a_n),
    .trig_b       (trig_b),
    .width_cycles (width_cycles),
    .pulse_q      (pulse_q),
    .pulse_qn     (pulse_qn)
);

// File: tb/oneshot_pulse_tb.sv
`timescale 1ns/1ps
module oneshot_pulse_tb;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig_a_n = 1'b1;
    logic             trig_b = 1'b0;
    logic [CNT_W-1:0] width_cycles = '0;
    logic             pulse_q;
    logic             pulse_qn;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    oneshot_pulse #(.CNT_W(CNT_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_a_n     (trig_a_n),
        .trig_b       (trig_b),
        .width_cycles (width_cycles),
        .pulse_q      (pulse_q),
        .pulse_qn     (pulse_qn)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_inputs();
        trig_a_n = 1'b1;
        trig_b   = 1'b0;
    endtask

    // Counts high samples from the current negedge; mode 1 drops the
    // trigger after the first sample, mode 2 toggles trig_b every cycle.
    task automatic measure(input string req, input int exp, input int mode);
        int len = 0;
        while (pulse_q === 1'b1 && len < 2000) begin
            len++;
            chk("R10", int'(pulse_qn), 0);
            if (mode == 1 && len == 1) idle_inputs();
            if (mode == 2) trig_b = ~trig_b;
            step();
        end
        chk(req, len, exp);
    endtask

    task automatic t_reset();
        step(4);
        chk("R4", int'(pulse_q), 0);
        chk("R4", int'(pulse_qn), 1);
        rst_n = 1'b1;
        step(2);
        chk("R4", int'(pulse_q), 0);
    endtask

    task automatic t_a_fall();
        width_cycles = 16'd5;
        trig_b = 1'b1;            // B rises with A high: no pulse
        step();
        step();
        chk("R2", int'(pulse_q), 0);
        trig_a_n = 1'b0;
        step();
        measure("R1", 5, 0);
        idle_inputs();
        step(2);
    endtask

    task automatic t_b_rise();
        width_cycles = 16'd3;
        trig_a_n = 1'b0;          // A falls with B low: no pulse
        step();
        step();
        chk("R1", int'(pulse_q), 0);
        trig_b = 1'b1;
        step();
        measure("R2", 3, 0);
        idle_inputs();
        step(2);
    endtask

    task automatic t_short_trigger();
        width_cycles = 16'd7;
        trig_a_n = 1'b0;
        step();
        trig_b = 1'b1;
        step();
        measure("R6", 7, 1);
        step(2);
    endtask

    task automatic t_ignore();
        width_cycles = 16'd6;
        trig_a_n = 1'b0;
        step();
        trig_b = 1'b1;
        step();
        measure("R3", 6, 2);
        idle_inputs();
        step(3);
        chk("R3", int'(pulse_q), 0);
    endtask

    task automatic t_width();
        width_cycles = 16'd0;
        trig_a_n = 1'b0;
        step();
        trig_b = 1'b1;
        step();
        measure("R7", 1, 0);
        idle_inputs();
        step(2);
        width_cycles = 16'd6;
        trig_a_n = 1'b0;
        step();
        trig_b = 1'b1;
        step();
        width_cycles = 16'd2;     // change after acceptance: no effect
        measure("R7", 6, 0);
        idle_inputs();
        step(2);
    endtask

    task automatic t_last_edge();
        width_cycles = 16'd4;
        trig_a_n = 1'b0;
        step();
        trig_b = 1'b1;
        step();                   // sample 1
        chk("R10", int'(pulse_q), 1);
        trig_b = 1'b0;
        step(3);                  // sample 4: final high cycle
        chk("R8", int'(pulse_q), 1);
        trig_b = 1'b1;            // rise lands on the final edge
        step();
        chk("R8", int'(pulse_q), 0);
        step();
        chk("R8", int'(pulse_q), 0);
        idle_inputs();
        step(2);
    endtask

    task automatic t_reset_abort();
        width_cycles = 16'd20;
        trig_a_n = 1'b0;
        step();
        trig_b = 1'b1;
        step(3);
        chk("R10", int'(pulse_q), 1);
        rst_n = 1'b0;
        idle_inputs();
        #1;
        chk("R4", int'(pulse_q), 0);
        chk("R4", int'(pulse_qn), 1);
        step(3);
        chk("R4", int'(pulse_q), 0);
        rst_n = 1'b1;
        step(3);
        chk("R4", int'(pulse_q), 0);
        step(20);
        chk("R4", int'(pulse_q), 0);
    endtask

    task automatic t_armed();
        width_cycles = 16'd5;
        rst_n = 1'b0;
        idle_inputs();
        step(2);
        trig_a_n = 1'b0;
        trig_b   = 1'b1;          // condition entered while held
        step(2);
        chk("R4", int'(pulse_q), 0);
        rst_n = 1'b1;
        step();
        measure("R5", 5, 0);      // condition held throughout: full length
        chk("R6", int'(pulse_q), 0);
        idle_inputs();
        step(2);
    endtask

    task automatic t_unarmed();
        width_cycles = 16'd2;
        trig_a_n = 1'b0;
        trig_b   = 1'b1;
        step();
        measure("R2", 2, 0);
        rst_n = 1'b0;             // condition already present
        step(3);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R5", int'(pulse_q), 0);
        end
        rst_n = 1'b0;
        idle_inputs();
        step(2);
        rst_n    = 1'b1;          // entry coincides with release
        trig_a_n = 1'b0;
        trig_b   = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R9", int'(pulse_q), 0);
        end
        idle_inputs();
        step(2);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        t_reset();
        t_a_fall();
        t_b_rise();
        t_short_trigger();
        t_ignore();
        t_width();
        t_last_edge();
        t_reset_abort();
        t_armed();
        t_unarmed();
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

endmodule